// File: doc/BRIEF.md
# Fault-Aware Set-Associative Cache Lookup Controller

This block is the lookup and allocation controller of one last-level cache slice that runs at a low supply voltage. At such a voltage some SRAM lines carry faulty bit-cells. Before normal traffic starts, a flush-and-configure phase loads a two-bit fault class for every line of every set. The value decides how that line is treated. A line with no faults is served at the base hit time. A line with one or two faults is served after an added correction delay. A line with more than two faults is switched off.

A request carries an address whose low bits select the set and whose high bits form the tag. After a request is accepted, the controller compares the tag against all enabled ways. On a hit it updates recency. On a miss it installs the tag into a way chosen by a fault-aware replacement rule. When no usable way is left in the set, it reports an uncacheable miss. Requests and responses both use valid/ready handshakes, and only one lookup is in flight at a time. The data array and the error-correction datapath sit outside this block. The response only reports which way was used and whether the correction path was taken.

Top module: `flt_cache_ctrl`

## Requirements
- R1: After reset every line is invalid with fault class 0, `req_ready` is 1 (with `cfg_mode` low) and `rsp_valid` is 0, so the first access to any set misses.
- R2: A write with `cfg_we`=1 while `cfg_mode`=1 stores `cfg_cls` for line (`cfg_set`, `cfg_way`) and makes that line invalid. A write with `cfg_mode`=0 is ignored, and the addressed line keeps its contents and its class.
- R3: Fault class 3 turns the line off. An off line never produces a hit and is never picked for allocation.
- R4: A miss, or a hit to a class-0 line, raises `rsp_valid` at the first clock edge after the edge that accepted the request, with `rsp_corr`=0.
- R5: A hit to a class-1 or class-2 line raises `rsp_valid` two clock edges later than R4, with `rsp_corr`=1.
- R6: `req_ready` is 0 from the accepting edge until the response has been taken, including the correction wait. It is also 0 whenever `cfg_mode` is 1.
- R7: A cacheable miss installs the tag into the lowest-numbered way that is enabled and invalid, and reports that way in `rsp_way` with `rsp_hit`=0.
- R8: When every enabled way of the set is valid, a miss replaces the enabled way used least recently. Both hits and fills count as uses. Off ways are skipped.
- R9: When every way of the set is off, the response has `rsp_uncached`=1, `rsp_hit`=0 and `rsp_corr`=0, and nothing is installed, so a repeat of the same address is again uncacheable.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields hold steady. The response is released at the first edge where `rsp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Flush-and-configure mode; blocks requests |
| cfg_we | input | 1 | Fault-class write strobe |
| cfg_set | input | SET_W | Set addressed by a fault-class write |
| cfg_way | input | WAY_W | Way addressed by a fault-class write |
| cfg_cls | input | 2 | Fault class: 0 none, 1 one bit, 2 two bits, 3 off |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | TAG_W+SET_W | Low SET_W bits select the set, the rest is the tag |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Way hit or filled (0 when uncacheable) |
| rsp_corr | output | 1 | Hit went through the correction delay |
| rsp_uncached | output | 1 | Every way of the set is off; nothing installed |

## Verification
The bench programs one set fully clean, one with mixed classes and one off way, one with a single usable way, and one with every way off. It then sweeps accesses against an arithmetic model of recency and classes. A controller that let an off way match or take a fill would report a way the model forbids. One that forgot the correction delay, or applied it to clean lines, would show a one-cycle or three-cycle latency in the wrong place. The sweep also covers a set reduced to a single usable way, where a wrong replacement rule would pick an off way or fail to evict. It covers a fully off set, where a faulty design would install a line and hit on the repeat. It also checks that a configuration write without the mode changes nothing, that a class write with the mode drops the line, and that a stalled response holds steady.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } fc_state_e;

  localparam logic [1:0] FCLS_NONE = 2'd0;
  localparam logic [1:0] FCLS_ONE  = 2'd1;
  localparam logic [1:0] FCLS_TWO  = 2'd2;
  localparam logic [1:0] FCLS_DEAD = 2'd3;

endpackage

// File: rtl/fc_tag_store.sv
module fc_tag_store
  import fc_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_en,
  input  logic [SET_W-1:0]                  cfg_set,
  input  logic [WAY_W-1:0]                  cfg_way,
  input  logic [1:0]                        cfg_cls,
  input  logic [SET_W-1:0]                  rd_set,
  output logic [WAYS-1:0]                   rd_valid,
  output logic [WAYS-1:0]                   rd_dis,
  output logic [WAYS-1:0][1:0]              rd_cls,
  output logic [WAYS-1:0][TAG_W-1:0]        rd_tag,
  output logic [WAYS-1:0][AGE_W-1:0]        rd_age,
  input  logic                              upd_en,
  input  logic                              upd_fill,
  input  logic [WAY_W-1:0]                  upd_way,
  input  logic [TAG_W-1:0]                  upd_tag
);

  logic [SETS-1:0][WAYS-1:0]             valid_q, valid_d;
  logic [SETS-1:0][WAYS-1:0]             dis_q,   dis_d;
  logic [SETS-1:0][WAYS-1:0][1:0]        cls_q,   cls_d;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q,   tag_d;
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  age_q,   age_d;
  logic                                  store_en;

  assign store_en = upd_en | cfg_en;

  // Read side: the whole set addressed by the lookup
  assign rd_valid = valid_q[rd_set];
  assign rd_dis   = dis_q[rd_set];
  assign rd_cls   = cls_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_age   = age_q[rd_set];

  // Next state: recency update and fill first, configuration last
  always_comb begin
    valid_d = valid_q;
    dis_d   = dis_q;
    cls_d   = cls_q;
    tag_d   = tag_q;
    age_d   = age_q;
    if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == upd_way) begin
          age_d[rd_set][w] = '0;
        end else if (age_q[rd_set][w] < age_q[rd_set][upd_way]) begin
          age_d[rd_set][w] = age_q[rd_set][w] + AGE_W'(1);
        end
      end
      if (upd_fill) begin
        valid_d[rd_set][upd_way] = 1'b1;
        tag_d[rd_set][upd_way]   = upd_tag;
      end
    end
    if (cfg_en) begin
      cls_d[cfg_set][cfg_way]   = cfg_cls;
      dis_d[cfg_set][cfg_way]   = (cfg_cls == FCLS_DEAD);
      valid_d[cfg_set][cfg_way] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dis_q   <= '0;
      cls_q   <= '0;
      tag_q   <= '0;
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= AGE_W'(w);
        end
      end
    end else if (store_en) begin
      valid_q <= valid_d;
      dis_q   <= dis_d;
      cls_q   <= cls_d;
      tag_q   <= tag_d;
      age_q   <= age_d;
    end
  end

  // R3: a fill chosen by the controller never lands in a switched-off line
  assert_no_fill_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_fill) |-> !dis_q[rd_set][upd_way]);

endmodule

// File: rtl/fc_lookup.sv
module fc_lookup
  import fc_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        chk_en,
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0]             way_dis,
  input  logic [WAYS-1:0][1:0]        way_cls,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [TAG_W-1:0]            req_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic [1:0]                  hit_cls
);

  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = way_valid[g] & ~way_dis[g] & (way_tag[g] == req_tag);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    hit_cls = FCLS_NONE;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        hit_way = WAY_W'(w);
        hit_cls = way_cls[w];
      end
    end
  end

  // R3: allocation only on a miss keeps every tag unique within a set
  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> $onehot0(match));

endmodule

// File: rtl/fc_victim.sv
module fc_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0]             way_dis,
  input  logic [WAYS-1:0][AGE_W-1:0]  way_age,
  output logic                        vic_ok,
  output logic [WAY_W-1:0]            vic_way
);

  logic             free_ok;
  logic [WAY_W-1:0] free_way;
  logic             old_ok;
  logic [WAY_W-1:0] old_way;
  logic [AGE_W-1:0] old_age;

  // Lowest-numbered enabled empty way
  always_comb begin
    free_ok  = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!way_dis[w] && !way_valid[w] && !free_ok) begin
        free_ok  = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  // Oldest enabled way
  always_comb begin
    old_ok  = 1'b0;
    old_way = '0;
    old_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!way_dis[w] && (!old_ok || (way_age[w] > old_age))) begin
        old_ok  = 1'b1;
        old_way = WAY_W'(w);
        old_age = way_age[w];
      end
    end
  end

  assign vic_ok  = old_ok;
  assign vic_way = free_ok ? free_way : old_way;

endmodule

// File: rtl/flt_cache_ctrl.sv
module flt_cache_ctrl
  import fc_pkg::*;
#(
  parameter int SETS     = 4,
  parameter int WAYS     = 4,
  parameter int TAG_W    = 6,
  parameter int CORR_CYC = 2,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int AGE_W  = $clog2(WAYS),
  localparam int ADDR_W = TAG_W + SET_W,
  localparam int CNT_W  = $clog2(CORR_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              cfg_we,
  input  logic [SET_W-1:0]  cfg_set,
  input  logic [WAY_W-1:0]  cfg_way,
  input  logic [1:0]        cfg_cls,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_corr,
  output logic              rsp_uncached
);

  fc_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              hit_q, hit_d;
  logic [WAY_W-1:0]  way_q, way_d;
  logic              corr_q, corr_d;
  logic              unc_q, unc_d;

  logic              accept;
  logic              addr_en;
  logic              rsp_en;
  logic              cfg_en;

  logic [SET_W-1:0]  look_set;
  logic [TAG_W-1:0]  look_tag;

  logic [WAYS-1:0]            rd_valid;
  logic [WAYS-1:0]            rd_dis;
  logic [WAYS-1:0][1:0]       rd_cls;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][AGE_W-1:0] rd_age;

  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way;
  logic [1:0]        lk_cls;
  logic              vic_ok;
  logic [WAY_W-1:0]  vic_way;

  logic              upd_en;
  logic              upd_fill;
  logic [WAY_W-1:0]  upd_way;

  assign look_set = addr_q[SET_W-1:0];
  assign look_tag = addr_q[ADDR_W-1:SET_W];
  assign cfg_en   = cfg_mode & cfg_we;

  assign req_ready    = (state_q == ST_IDLE) && !cfg_mode;
  assign accept       = req_valid && req_ready;
  assign addr_en      = accept;
  assign rsp_en       = (state_q == ST_LOOK);
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_hit      = hit_q;
  assign rsp_way      = way_q;
  assign rsp_corr     = corr_q;
  assign rsp_uncached = unc_q;

  fc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_set  (cfg_set),
    .cfg_way  (cfg_way),
    .cfg_cls  (cfg_cls),
    .rd_set   (look_set),
    .rd_valid (rd_valid),
    .rd_dis   (rd_dis),
    .rd_cls   (rd_cls),
    .rd_tag   (rd_tag),
    .rd_age   (rd_age),
    .upd_en   (upd_en),
    .upd_fill (upd_fill),
    .upd_way  (upd_way),
    .upd_tag  (look_tag)
  );

  fc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_en    (rsp_en),
    .way_valid (rd_valid),
    .way_dis   (rd_dis),
    .way_cls   (rd_cls),
    .way_tag   (rd_tag),
    .req_tag   (look_tag),
    .hit       (lk_hit),
    .hit_way   (lk_way),
    .hit_cls   (lk_cls)
  );

  fc_victim #(.WAYS(WAYS)) u_victim (
    .way_valid (rd_valid),
    .way_dis   (rd_dis),
    .way_age   (rd_age),
    .vic_ok    (vic_ok),
    .vic_way   (vic_way)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    hit_d    = hit_q;
    way_d    = way_q;
    corr_d   = corr_q;
    unc_d    = unc_q;
    upd_en   = 1'b0;
    upd_fill = 1'b0;
    upd_way  = '0;
    case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_LOOK;
      end
      ST_LOOK: begin
        hit_d  = 1'b0;
        corr_d = 1'b0;
        unc_d  = 1'b0;
        if (lk_hit) begin
          upd_en  = 1'b1;
          upd_way = lk_way;
          hit_d   = 1'b1;
          way_d   = lk_way;
          if (lk_cls != FCLS_NONE) begin
            corr_d  = 1'b1;
            cnt_d   = CNT_W'(CORR_CYC - 1);
            state_d = ST_WAIT;
          end else begin
            state_d = ST_RESP;
          end
        end else if (vic_ok) begin
          upd_en   = 1'b1;
          upd_fill = 1'b1;
          upd_way  = vic_way;
          way_d    = vic_way;
          state_d  = ST_RESP;
        end else begin
          unc_d   = 1'b1;
          way_d   = '0;
          state_d = ST_RESP;
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) state_d = ST_RESP;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      way_q  <= '0;
      corr_q <= 1'b0;
      unc_q  <= 1'b0;
    end else if (rsp_en) begin
      hit_q  <= hit_d;
      way_q  <= way_d;
      corr_q <= corr_d;
      unc_q  <= unc_d;
    end
  end

  // R6: one lookup at a time
  assert_one_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10: a stalled response holds its fields
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_way)
                                   && $stable(rsp_corr) && $stable(rsp_uncached)));

  // R9: an uncacheable answer is never a hit
  assert_uncached_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_uncached) |-> (!rsp_hit && !rsp_corr));

  // R5: the correction flag only accompanies hits
  assert_corr_only_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_corr) |-> rsp_hit);

  // R4: an uncorrected answer appears one edge after acceptance
  assert_fast_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && !rsp_corr) |-> $past(req_valid && req_ready, 2));

endmodule

// File: tb/flt_cache_ctrl_bench.sv
module flt_cache_ctrl_bench;

  localparam int SETS   = 4;
  localparam int WAYS   = 4;
  localparam int TAG_W  = 6;
  localparam int SET_W  = 2;
  localparam int WAY_W  = 2;
  localparam int ADDR_W = TAG_W + SET_W;

  logic              clk;
  logic              rst_n;
  logic              cfg_mode;
  logic              cfg_we;
  logic [SET_W-1:0]  cfg_set;
  logic [WAY_W-1:0]  cfg_way;
  logic [1:0]        cfg_cls;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic              rsp_valid;
  logic              rsp_ready;
  logic              rsp_hit;
  logic [WAY_W-1:0]  rsp_way;
  logic              rsp_corr;
  logic              rsp_uncached;

  int n_run;
  int n_fail;

  int m_valid [SETS][WAYS];
  int m_tag   [SETS][WAYS];
  int m_cls   [SETS][WAYS];
  int m_age   [SETS][WAYS];

  flt_cache_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_flt_cache_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode     (cfg_mode),
    .cfg_we       (cfg_we),
    .cfg_set      (cfg_set),
    .cfg_way      (cfg_way),
    .cfg_cls      (cfg_cls),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_hit      (rsp_hit),
    .rsp_way      (rsp_way),
    .rsp_corr     (rsp_corr),
    .rsp_uncached (rsp_uncached)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic touch(input int s, input int w);
    for (int v = 0; v < WAYS; v++) begin
      if (v != w && m_age[s][v] < m_age[s][w]) m_age[s][v]++;
    end
    m_age[s][w] = 0;
  endtask

  task automatic cfg_write(input int s, input int w, input int cls, input bit mode);
    @(negedge clk);
    cfg_mode = mode;
    cfg_we   = 1'b1;
    cfg_set  = SET_W'(s);
    cfg_way  = WAY_W'(w);
    cfg_cls  = 2'(cls);
    #1;
    if (mode) chk("R6", "req_ready in cfg mode", int'(req_ready), 0);
    @(negedge clk);
    cfg_we   = 1'b0;
    cfg_mode = 1'b0;
    if (mode) begin
      m_cls[s][w]   = cls;
      m_valid[s][w] = 0;
    end
  endtask

  task automatic access(input int s, input int t, input string rq, input int hold);
    bit ehit, ecorr, eunc;
    int ew, elat, lat, bw, bage;
    string lrq;
    ehit = 0; ecorr = 0; eunc = 0; ew = 0;
    for (int w = 0; w < WAYS; w++) begin
      if (m_valid[s][w] != 0 && m_cls[s][w] != 3 && m_tag[s][w] == t) begin
        ehit = 1; ew = w; ecorr = (m_cls[s][w] != 0);
      end
    end
    if (!ehit) begin
      bw = -1;
      for (int w = 0; w < WAYS; w++)
        if (m_cls[s][w] != 3 && m_valid[s][w] == 0 && bw < 0) bw = w;
      if (bw < 0) begin
        bage = -1;
        for (int w = 0; w < WAYS; w++)
          if (m_cls[s][w] != 3 && m_age[s][w] > bage) begin bage = m_age[s][w]; bw = w; end
      end
      if (bw < 0) eunc = 1; else ew = bw;
    end
    elat = ecorr ? 3 : 1;
    lrq  = ecorr ? "R5" : "R4";

    @(negedge clk);
    chk("R6", "req_ready idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = ADDR_W'((t << SET_W) | s);
    rsp_ready = (hold == 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6", "req_ready after accept", int'(req_ready), 0);
    lat = 0;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
      if (!rsp_valid) chk("R6", "req_ready while waiting", int'(req_ready), 0);
    end
    chk(lrq, "latency", lat, elat);
    chk(rq, "rsp_hit", int'(rsp_hit), int'(ehit));
    if (!eunc) chk(rq, "rsp_way", int'(rsp_way), ew);
    chk("R5", "rsp_corr", int'(rsp_corr), int'(ecorr));
    chk("R9", "rsp_uncached", int'(rsp_uncached), int'(eunc));
    chk("R6", "req_ready with response", int'(req_ready), 0);
    if (hold > 0) begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk("R10", "held rsp_valid", int'(rsp_valid), 1);
        chk("R10", "held rsp_hit", int'(rsp_hit), int'(ehit));
        chk("R10", "held rsp_way", int'(rsp_way), ew);
        chk("R10", "held rsp_corr", int'(rsp_corr), int'(ecorr));
      end
      rsp_ready = 1'b1;
    end
    @(negedge clk);
    chk("R10", "response released", int'(rsp_valid), 0);
    if (ehit) begin
      touch(s, ew);
    end else if (!eunc) begin
      m_valid[s][ew] = 1;
      m_tag[s][ew]   = t;
      touch(s, ew);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; cfg_mode = 1'b0; cfg_we = 1'b0; cfg_set = '0; cfg_way = '0;
    cfg_cls = '0; req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b1;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 0; m_tag[s][w] = 0; m_cls[s][w] = 0; m_age[s][w] = w;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready after reset", int'(req_ready), 1);
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    access(0, 9, "R1", 0);

    // Fault classes: set 0 clean, set 1 mixed, set 2 one usable way, set 3 all off
    for (int w = 0; w < WAYS; w++) begin
      cfg_write(0, w, 0, 1'b1);
      cfg_write(1, w, (w == 0) ? 1 : (w == 1) ? 2 : (w == 2) ? 3 : 0, 1'b1);
      cfg_write(2, w, (w == 2) ? 0 : 3, 1'b1);
      cfg_write(3, w, 3, 1'b1);
    end
    // R2: writes without the mode must be ignored
    cfg_write(0, 0, 3, 1'b0);
    cfg_write(1, 0, 3, 1'b0);

    // Set 0: fills, clean hits, LRU sweep
    for (int t = 1; t <= 4; t++) access(0, t, "R7", 0);
    chk("R2", "way0 still usable", m_tag[0][0], 1);
    for (int t = 1; t <= 4; t++) access(0, t, "R2", 0);
    for (int i = 0; i < 16; i++) access(0, ((i * 5) % 7) + 1, "R8", 0);

    // Set 1: off way skipped, corrected hits
    for (int t = 1; t <= 3; t++) access(1, t, "R3", 0);
    access(1, 4, "R8", 0);
    access(1, 2, "R5", 0);
    access(1, 3, "R4", 0);
    access(1, 4, "R5", 0);
    access(1, 2, "R10", 3);
    access(1, 3, "R10", 2);

    // Set 2: single usable way
    access(2, 1, "R3", 0);
    access(2, 1, "R3", 0);
    access(2, 2, "R3", 0);
    access(2, 1, "R8", 0);

    // Set 3: no usable way
    access(3, 1, "R9", 0);
    access(3, 1, "R9", 0);

    // R2: reconfigure drops the line; ignored write left way0 working
    access(1, 4, "R2", 0);
    cfg_write(1, 1, 0, 1'b1);
    access(1, 2, "R2", 0);
    access(1, 2, "R4", 0);
    cfg_write(2, 2, 3, 1'b1);
    access(2, 1, "R3", 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule